// File: doc/BRIEF.md
# Banked Interrupt Priority Register File

This block holds one 8-bit priority per interrupt line and lets software read and write those priorities through byte-wide and 32-bit accesses addressed by byte offset, where byte offset k names interrupt k. Every access is tagged as secure or non-secure. When security is in force (the security-disable input is low), a non-secure access may only touch interrupts whose group bit is 1. It sees those priorities through a half-range window: the stored value appears shifted left by one, and a written value is stored shifted right by one with the top bit forced high.

Only interrupts from 32 up to the implemented count hold a priority. The lower 32 and anything at or past the implemented count read as zero and drop writes. The stored priorities leave the block on a flat vector for the arbitration logic. Each write that is accepted raises a one-cycle update strobe carrying the first affected interrupt index and how many interrupts it covers, so that downstream logic can re-evaluate them.

Top module: `irq_prio_regfile`

## Requirements
- R1: After reset every stored priority is 0, `prio_out` is all zeros and `upd_valid` is low.
- R2: An interrupt index below 32 or at or above NUM_IRQ reads as 0 on any access, and a byte write to it changes nothing and raises no strobe.
- R3: A non-secure access with `sec_disable` low to an interrupt whose group bit is 0 reads as 0 and leaves that priority unchanged.
- R4: A permitted non-secure read with `sec_disable` low returns the stored priority shifted left by one, truncated to 8 bits.
- R5: A permitted non-secure write with `sec_disable` low stores 0x80 ORed with the written byte shifted right by one.
- R6: A secure access, or any access while `sec_disable` is high, reads and writes the stored priority unchanged, whatever the group bits.
- R7: `acc_word`=1 selects a 32-bit access at offset k: bits 8i+7:8i carry interrupt k+i for i=0..3. `acc_word`=0 selects a byte access: it uses `acc_wdata[7:0]` and returns the priority in `rd_data[7:0]`, with bits 31:8 zero.
- R8: A 32-bit write is dropped as a whole, with no strobe, when k is below 32 or k+3 is at or above NUM_IRQ. A 32-bit read checks each of its four interrupts on its own.
- R9: In the cycle after a write is accepted on range, `upd_valid` is high for exactly one cycle with `upd_base`=k and `upd_count`=1 for a byte or 4 for a word. This holds even when the group check blocks some lanes. A read never raises the strobe.
- R10: `prio_out` bits 8j+7:8j hold the stored priority of interrupt j, and a write shows up there one clock after the access is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| acc_secure | input | 1 | 1 = secure access attribute |
| acc_offset | input | OFF_W | Byte offset, equal to the first interrupt index |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational during a read access |
| group_bits | input | NUM_IRQ | Per-interrupt group bit; 1 allows non-secure access |
| sec_disable | input | 1 | 1 = single security state, no non-secure filtering |
| prio_out | output | NUM_IRQ*8 | All stored priorities, interrupt j at bits 8j+7:8j |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_base | output | OFF_W | First interrupt index of the update |
| upd_count | output | 3 | Number of interrupts updated (1 or 4) |

## Verification
The sweeps cover the range edges at 31/32 and NUM_IRQ-1/NUM_IRQ, so an off-by-one range test that let interrupt 31 or NUM_IRQ be written would show up as a nonzero read-back. Word writes are placed so that they straddle the top edge. A design that wrote the lanes that fit, instead of dropping the whole word, would leave partial data behind. Non-secure traffic runs with a mixed group pattern, which catches a view transform applied in the wrong direction, a missing forced top bit, or a group filter that leaks blocked priorities. The strobe is checked after every access: it must be absent for reads and for range-rejected writes, and present for a word write whose lanes the group check blocked in part.

// File: rtl/prio_pkg.sv
// Package: shared constants and the non-secure view transforms of the
// priority register file. Assumes an 8-bit priority and a 4-lane word.
package prio_pkg;
    localparam int PRIO_W       = 8;
    localparam int LANES        = 4;
    localparam int FIRST_SHARED = 32;

    // Non-secure read view: half range shifted up.
    function automatic logic [PRIO_W-1:0] ns_rd_view(input logic [PRIO_W-1:0] p);
        return {p[PRIO_W-2:0], 1'b0};
    endfunction

    // Non-secure write view: top bit forced, value shifted down.
    function automatic logic [PRIO_W-1:0] ns_wr_view(input logic [PRIO_W-1:0] d);
        return {1'b1, d[PRIO_W-1:1]};
    endfunction
endpackage

// File: rtl/prio_lane_gate.sv
// Module: per-lane access filter. Decides whether one interrupt index may be
// touched by the current access and applies the non-secure view transform.
// Assumes the index is wide enough never to wrap for offset+3.
module prio_lane_gate #(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = 11
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_IRQ-1:0] group_vec,
    input  logic               ns_restrict,
    input  logic [7:0]         raw_prio,
    input  logic [7:0]         wr_byte,
    output logic               in_range,
    output logic               permit,
    output logic [7:0]         rd_view,
    output logic [7:0]         wr_view
);
    import prio_pkg::*;

    logic grp_sel;

    // Select the group bit for this index without an out-of-range part select.
    always_comb begin
        grp_sel = 1'b0;
        for (int j = 0; j < NUM_IRQ; j++) begin
            if (idx == IDX_W'(j)) grp_sel = group_vec[j];
        end
    end

    // Range test, permission and both data transforms.
    always_comb begin
        in_range = (idx >= IDX_W'(FIRST_SHARED)) && (idx < IDX_W'(NUM_IRQ));
        permit   = in_range && (!ns_restrict || grp_sel);
        if (!permit)          rd_view = 8'h00;
        else if (ns_restrict) rd_view = ns_rd_view(raw_prio);
        else                  rd_view = raw_prio;
        wr_view  = ns_restrict ? ns_wr_view(wr_byte) : wr_byte;
    end
endmodule

// File: rtl/prio_store.sv
// Module: flop array of per-interrupt priorities with one write port per lane.
// Assumes lanes in the same cycle carry distinct indices.
module prio_store #(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [prio_pkg::LANES-1:0] lane_we,
    input  logic [IDX_W-1:0]           lane_idx [prio_pkg::LANES],
    input  logic [7:0]                 lane_wd  [prio_pkg::LANES],
    input  logic                       ns_restrict,
    output logic [7:0]                 lane_rd  [prio_pkg::LANES],
    output logic [NUM_IRQ*8-1:0]       prio_flat
);
    import prio_pkg::*;

    logic [7:0] prio_q [NUM_IRQ];

    // Write any entry addressed by an enabled lane; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_IRQ; j++) prio_q[j] <= 8'h00;
        end else begin
            for (int j = 0; j < NUM_IRQ; j++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_we[l] && lane_idx[l] == IDX_W'(j)) prio_q[j] <= lane_wd[l];
                end
            end
        end
    end

    // Raw read mux per lane.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rd[l] = 8'h00;
            for (int j = 0; j < NUM_IRQ; j++) begin
                if (lane_idx[l] == IDX_W'(j)) lane_rd[l] = prio_q[j];
            end
        end
    end

    genvar gj;
    generate
        for (gj = 0; gj < NUM_IRQ; gj++) begin : g_ent
            logic hit;
            assign prio_flat[gj*8 +: 8] = prio_q[gj];

            // Flag whether any lane writes this entry.
            always_comb begin
                hit = 1'b0;
                for (int l = 0; l < LANES; l++) begin
                    if (lane_we[l] && lane_idx[l] == IDX_W'(gj)) hit = 1'b1;
                end
            end

            if (gj < FIRST_SHARED) begin : g_low
                assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    prio_q[gj] == 8'h00);
            end

            assert_ns_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && ns_restrict) |=> prio_q[gj][7]);
        end
    endgenerate
endmodule

// File: rtl/prio_update_strobe.sv
// Module: registers the one-cycle update notification for accepted writes.
module prio_update_strobe #(
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             is_word,
    input  logic [OFF_W-1:0] base,
    output logic             upd_valid,
    output logic [OFF_W-1:0] upd_base,
    output logic [2:0]       upd_count
);
    // Capture base and count alongside the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_base  <= '0;
            upd_count <= 3'd0;
        end else begin
            upd_valid <= fire;
            upd_base  <= base;
            upd_count <= is_word ? 3'd4 : 3'd1;
        end
    end

    assert_count_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_count == 3'd1 || upd_count == 3'd4));
endmodule

// File: rtl/irq_prio_regfile.sv
// Module: top of the banked priority register file. Splits an access into
// four lanes, filters each lane by range and security, stores accepted
// bytes and raises an update strobe. Assumes acc_* is held for one cycle
// per access and that NUM_IRQ <= 2**OFF_W.
module irq_prio_regfile #(
    parameter int NUM_IRQ = 64,
    parameter int OFF_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_word,
    input  logic                 acc_secure,
    input  logic [OFF_W-1:0]     acc_offset,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          rd_data,
    input  logic [NUM_IRQ-1:0]   group_bits,
    input  logic                 sec_disable,
    output logic [NUM_IRQ*8-1:0] prio_out,
    output logic                 upd_valid,
    output logic [OFF_W-1:0]     upd_base,
    output logic [2:0]           upd_count
);
    import prio_pkg::*;
    localparam int IDX_W = OFF_W + 1;

    logic             ns_restrict;
    logic [LANES-1:0] lane_act, lane_inr, lane_perm, lane_we;
    logic [IDX_W-1:0] lane_idx [LANES];
    logic [7:0]       lane_raw [LANES];
    logic [7:0]       lane_rdv [LANES];
    logic [7:0]       lane_wrv [LANES];
    logic             range_ok, write_ok;

    assign ns_restrict = !acc_secure && !sec_disable;

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            assign lane_idx[gl] = {1'b0, acc_offset} + IDX_W'(gl);
            assign lane_act[gl] = acc_valid && (acc_word || gl == 0);

            prio_lane_gate #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_gate (
                .idx         (lane_idx[gl]),
                .group_vec   (group_bits),
                .ns_restrict (ns_restrict),
                .raw_prio    (lane_raw[gl]),
                .wr_byte     (acc_wdata[gl*8 +: 8]),
                .in_range    (lane_inr[gl]),
                .permit      (lane_perm[gl]),
                .rd_view     (lane_rdv[gl]),
                .wr_view     (lane_wrv[gl])
            );

            assign lane_we[gl] = write_ok && lane_act[gl] && lane_perm[gl];
            assign rd_data[gl*8 +: 8] = (lane_act[gl] && !acc_write) ? lane_rdv[gl] : 8'h00;
        end
    endgenerate

    // Whole-access range acceptance: a word needs all four lanes implemented.
    always_comb begin
        range_ok = acc_word ? (&lane_inr) : lane_inr[0];
        write_ok = acc_valid && acc_write && range_ok;
    end

    prio_store #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_we     (lane_we),
        .lane_idx    (lane_idx),
        .lane_wd     (lane_wrv),
        .ns_restrict (ns_restrict),
        .lane_rd     (lane_raw),
        .prio_flat   (prio_out)
    );

    prio_update_strobe #(.OFF_W(OFF_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (write_ok),
        .is_word   (acc_word),
        .base      (acc_offset),
        .upd_valid (upd_valid),
        .upd_base  (upd_base),
        .upd_count (upd_count)
    );

    assert_word_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_word && !(&lane_inr)) |=> ($stable(prio_out) && !upd_valid));

    assert_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> (!upd_valid && $stable(prio_out)));

    assert_byte_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_word) |-> (rd_data[31:8] == 24'h0));
endmodule

// File: tb/sim_irq_prio_regfile.sv
module sim_irq_prio_regfile;
    localparam int N = 64;

    logic clk = 0, rst_n = 0;
    logic acc_valid = 0, acc_write = 0, acc_word = 0, acc_secure = 0;
    logic [9:0]  acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [N-1:0] group_bits = '0;
    logic sec_disable = 0;
    logic [N*8-1:0] prio_out;
    logic upd_valid;
    logic [9:0] upd_base;
    logic [2:0] upd_count;

    int errors = 0, checks = 0;
    logic [7:0] m [N];

    always #5 clk = ~clk;

    irq_prio_regfile u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit inr(input int i);
        return i >= 32 && i < N;
    endfunction

    function automatic bit perm(input int i, input bit sec);
        return inr(i) && (sec || sec_disable || group_bits[i]);
    endfunction

    function automatic logic [7:0] exp_rd(input int i, input bit sec);
        if (!perm(i, sec)) return 8'h00;
        if (!sec && !sec_disable) return {m[i][6:0], 1'b0};
        return m[i];
    endfunction

    function automatic void mdl_wr(input int i, input bit sec, input logic [7:0] d);
        if (perm(i, sec)) m[i] = (!sec && !sec_disable) ? {1'b1, d[7:1]} : d;
    endfunction

    // One access: drive at negedge, sample read before the edge, strobe after it.
    task automatic acc(input bit wr, input bit wd, input bit sec, input int off,
                       input logic [31:0] d, output logic [31:0] rd,
                       output logic uv, output logic [9:0] ub, output logic [2:0] uc);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_word = wd; acc_secure = sec;
        acc_offset = 10'(off); acc_wdata = d;
        #2 rd = rd_data;
        @(posedge clk);
        #1 uv = upd_valid; ub = upd_base; uc = upd_count;
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic do_byte(input bit wr, input bit sec, input int off, input logic [7:0] d);
        logic [31:0] rd; logic uv; logic [9:0] ub; logic [2:0] uc;
        logic [7:0] e;
        e = exp_rd(off, sec);
        acc(wr, 0, sec, off, {24'h0, d}, rd, uv, ub, uc);
        if (!wr) begin
            chk("R2/R3/R4/R6/R7 byte read", rd, {24'h0, e});
            chk("R9 no strobe on read", {31'h0, uv}, 32'h0);
        end else begin
            chk("R9/R2 byte strobe", {31'h0, uv}, {31'h0, inr(off)});
            if (inr(off)) chk("R9 byte base/count", {19'h0, ub, uc}, {19'h0, 10'(off), 3'd1});
            mdl_wr(off, sec, d);
        end
    endtask

    task automatic do_word(input bit wr, input bit sec, input int off, input logic [31:0] d);
        logic [31:0] rd, e; logic uv; logic [9:0] ub; logic [2:0] uc;
        bit ok;
        for (int l = 0; l < 4; l++) e[l*8 +: 8] = exp_rd(off + l, sec);
        ok = off >= 32 && off + 3 < N;
        acc(wr, 1, sec, off, d, rd, uv, ub, uc);
        if (!wr) begin
            chk("R7/R8 word read lanes", rd, e);
        end else begin
            chk("R8/R9 word strobe", {31'h0, uv}, {31'h0, ok});
            if (ok) begin
                chk("R9 word base/count", {19'h0, ub, uc}, {19'h0, 10'(off), 3'd4});
                for (int l = 0; l < 4; l++) mdl_wr(off + l, sec, d[l*8 +: 8]);
            end
        end
    endtask

    task automatic cmp_all(input string req);
        for (int i = 0; i < N; i++) chk(req, {24'h0, prio_out[i*8 +: 8]}, {24'h0, m[i]});
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 chk("R1 strobe low after reset", {31'h0, upd_valid}, 32'h0);
        cmp_all("R1 priorities zero after reset");
        @(negedge clk) rst_n = 1;

        // Secure byte sweep across both range edges.
        for (int i = 0; i < N + 4; i++) do_byte(1, 1, i, 8'((i * 37 + 11) & 8'hFF));
        for (int i = 0; i < N + 4; i++) do_byte(0, 1, i, 8'h00);
        @(negedge clk) cmp_all("R10 prio_out after secure writes");

        // Non-secure with security enabled and a mixed group pattern.
        for (int i = 0; i < N; i++) group_bits[i] = (i % 3 != 1);
        for (int i = 28; i < N + 2; i++) do_byte(0, 0, i, 8'h00);
        for (int i = 28; i < N + 2; i++) do_byte(1, 0, i, 8'((i * 91 + 5) & 8'hFF));
        for (int i = 28; i < N + 2; i++) do_byte(0, 1, i, 8'h00);
        @(negedge clk) cmp_all("R5/R3 prio_out after non-secure writes");

        // Security disabled: raw view for non-secure, group ignored.
        sec_disable = 1;
        for (int i = 30; i < 40; i++) do_byte(1, 0, i, 8'(i + 8'h40));
        for (int i = 30; i < 40; i++) do_byte(0, 0, i, 8'h00);
        sec_disable = 0;

        // Word writes straddling both edges, secure then non-secure.
        for (int k = 26; k < N + 2; k += 3) do_word(1, 1, k, 32'hA1B2C3D4 ^ 32'(k * 32'h01010101));
        for (int k = 26; k < N + 2; k++) do_word(0, 1, k, 32'h0);
        for (int k = 32; k < N - 3; k += 5) do_word(1, 0, k, 32'h5F0E9C27 + 32'(k));
        for (int k = 26; k < N + 2; k++) do_word(0, 0, k, 32'h0);
        @(negedge clk) cmp_all("R10/R8 prio_out after word writes");

        // Strobe lasts one cycle.
        do_byte(1, 1, 40, 8'h33);
        @(posedge clk); #1 chk("R9 strobe one cycle", {31'h0, upd_valid}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule